// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-Bit Timer Registers

This block sits between an 8-bit processor data bus and a bank of 16-bit timer registers: the running count, two compare values and the capture value. Each 16-bit value is split into a low byte and a high byte, and each byte has its own bus address. A single shared holding byte stores the upper half of a transfer. This lets software move a full 16-bit value as one indivisible step, even though the bus carries only one byte per access.

To write a register, software stores the upper byte first. That write only fills the holding byte. The following low-byte write then presents the holding byte and the new low byte together on that register's write port, with a one-cycle load strobe. To read a register, software fetches the low byte first. That read returns the live low byte and, at the same clock edge, copies the live high byte into the holding byte. A later read of the high-byte address returns the holding byte, so both halves come from the same instant.

Because one holding byte serves every register, a stray access to a different register between the two halves of a transfer corrupts the value. The bridge offers no protection against this. The registers' own behaviour (counting, comparing, capturing) lies outside this block, which only sees each register's live value and drives its load port.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the holding byte is 0x00, so a high-byte read before any other access returns 0x00.
- R2: A write to a mapped high-byte address (bit 0 of the address = 1) stores the data byte in the holding byte and asserts no load strobe.
- R3: A write to the low-byte address of register k asserts only load strobe k, combinationally in that same cycle, and presents {holding byte, written byte} on that register's write port.
- R4: A read of register k's low-byte address returns bits 7:0 of register k's live value in the same cycle.
- R5: At the clock edge that ends a low-byte read of register k, bits 15:8 of register k's live value are copied into the holding byte.
- R6: A read of a mapped high-byte address returns the holding byte, not the live high byte.
- R7: The holding byte is shared: a high-byte write for one register followed by a low-byte write to another register loads the second register with the stored byte.
- R8: Register k occupies address 2k (low byte) and 2k+1 (high byte). Addresses at or above 2·NUM_REGS are unmapped: writes to them load nothing and leave the holding byte unchanged, and reads of them return 0x00.
- R9: When the write and read strobes are asserted together, the cycle is a write. The read has no effect: the read data is 0x00 and nothing is captured.
- R10: With no strobe asserted, the read data is 0x00 and no load strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address; bit 0 selects the high half |
| bus_wdata | input | BUS_W | Byte written by the processor |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | BUS_W | Byte returned for a read; 0 otherwise |
| reg_live | input | NUM_REGS*REG_W | Live value of each register, register k at bits k*REG_W upward |
| reg_wdata | output | NUM_REGS*REG_W | 16-bit value offered to each register's write port |
| reg_load | output | NUM_REGS | Per-register load strobe |

## Verification
The bench builds the bridge with four registers and a 4-bit address. This leaves half of the address space unmapped, so the bench exercises the ignored writes and zero reads of R8 alongside every low and high byte of every mapped register. The bench changes the live values between accesses. This separates the captured high byte from the current one, and it lets random sequences interleave accesses to different registers so that the shared-holding-byte corruption of R7 occurs often.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_READ  = 2'd2
   } acc_kind_e;

   // Smallest byte address width able to reach every register's two halves.
   function automatic int unsigned min_addr_bits(input int unsigned nregs);
      int unsigned bits;
      bits = $clog2(2 * nregs);
      return (bits < 2) ? 2 : bits;
   endfunction

endpackage

// File: rtl/wrb_addr_decode.sv
module wrb_addr_decode
   import wrb_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr,
   input  logic                rd,
   output logic [NUM_REGS-1:0] sel,
   output logic                hi_half,
   output logic                mapped,
   output acc_kind_e           acc
);

   localparam int unsigned IDX_W = ADDR_W - 1;

   logic [IDX_W-1:0] idx;

   assign idx     = addr[ADDR_W-1:1];
   assign hi_half = addr[0];

   // One select line per register, each matching its own word index.
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
      assign sel[k] = (idx == IDX_W'(k));
   end

   assign mapped = |sel;

   // A write strobe wins over a simultaneous read strobe.
   always_comb begin
      if (wr)      acc = ACC_WRITE;
      else if (rd) acc = ACC_READ;
      else         acc = ACC_IDLE;
   end

endmodule

// File: rtl/wrb_temp_byte.sv
module wrb_temp_byte #(
   parameter int unsigned       BUS_W     = 8,
   parameter logic [BUS_W-1:0]  RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             cap_en,
   input  logic [BUS_W-1:0] cap_data,
   output logic [BUS_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RESET_VAL;
      end else if (wr_en) begin
         q <= wr_data;
      end else if (cap_en) begin
         q <= cap_data;
      end
   end

endmodule

// File: rtl/wrb_read_mux.sv
module wrb_read_mux #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned BUS_W    = 8,
   parameter int unsigned REG_W    = 16
) (
   input  logic [NUM_REGS-1:0]       sel,
   input  logic                      hi_half,
   input  logic                      rd_active,
   input  logic [NUM_REGS*REG_W-1:0] live,
   input  logic [BUS_W-1:0]          temp,
   output logic [BUS_W-1:0]          rdata,
   output logic [BUS_W-1:0]          live_hi
);

   logic [BUS_W-1:0] lo_masked [NUM_REGS];
   logic [BUS_W-1:0] hi_masked [NUM_REGS];
   logic [BUS_W-1:0] lo_any;
   logic [BUS_W-1:0] hi_any;

   // AND-OR selection: the select vector is one-hot or empty.
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_mask
      assign lo_masked[k] = sel[k] ? live[k*REG_W +: BUS_W]         : '0;
      assign hi_masked[k] = sel[k] ? live[k*REG_W + BUS_W +: BUS_W] : '0;
   end

   always_comb begin
      lo_any = '0;
      hi_any = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         lo_any = lo_any | lo_masked[k];
         hi_any = hi_any | hi_masked[k];
      end
   end

   assign live_hi = hi_any;
   assign rdata   = !rd_active ? '0 : (hi_half ? temp : lo_any);

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
   import wrb_pkg::*;
#(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned BUS_W    = 8,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [BUS_W-1:0]          bus_wdata,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   output logic [BUS_W-1:0]          bus_rdata,
   input  logic [NUM_REGS*REG_W-1:0] reg_live,
   output logic [NUM_REGS*REG_W-1:0] reg_wdata,
   output logic [NUM_REGS-1:0]       reg_load
);

   localparam int unsigned MIN_ADDR_W = min_addr_bits(NUM_REGS);

   // Elaboration-time parameter checks.
   if (NUM_REGS < 1) begin : g_bad_count
      $error("wide_reg_bridge: NUM_REGS must be at least 1");
   end
   if (REG_W != 2 * BUS_W) begin : g_bad_width
      $error("wide_reg_bridge: REG_W must be twice BUS_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("wide_reg_bridge: ADDR_W too small for NUM_REGS");
   end

   logic [NUM_REGS-1:0] sel;
   logic                hi_half;
   logic                mapped;
   acc_kind_e           acc;
   logic                wr_hit;
   logic                rd_hit;
   logic [BUS_W-1:0]    temp_q;
   logic [BUS_W-1:0]    live_hi;

   wrb_addr_decode #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W)
   ) u_decode (
      .addr    (bus_addr),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .sel     (sel),
      .hi_half (hi_half),
      .mapped  (mapped),
      .acc     (acc)
   );

   assign wr_hit = (acc == ACC_WRITE) && mapped;
   assign rd_hit = (acc == ACC_READ)  && mapped;

   wrb_temp_byte #(
      .BUS_W     (BUS_W),
      .RESET_VAL ('0)
   ) u_temp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_hit && hi_half),
      .wr_data  (bus_wdata),
      .cap_en   (rd_hit && !hi_half),
      .cap_data (live_hi),
      .q        (temp_q)
   );

   wrb_read_mux #(
      .NUM_REGS (NUM_REGS),
      .BUS_W    (BUS_W),
      .REG_W    (REG_W)
   ) u_rmux (
      .sel       (sel),
      .hi_half   (hi_half),
      .rd_active (rd_hit),
      .live      (reg_live),
      .temp      (temp_q),
      .rdata     (bus_rdata),
      .live_hi   (live_hi)
   );

   // Write ports: every register sees the same merged word; only the
   // addressed one is strobed, and only on a low-byte write.
   for (genvar k = 0; k < NUM_REGS; k++) begin : g_wport
      assign reg_wdata[k*REG_W +: REG_W] = {temp_q, bus_wdata};
      assign reg_load[k]                 = wr_hit && !hi_half && sel[k];
   end

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned BUS_W    = 8,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned ADDR_W   = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [BUS_W-1:0]          bus_wdata,
   input logic                      bus_wr,
   input logic                      bus_rd,
   input logic [BUS_W-1:0]          bus_rdata,
   input logic [NUM_REGS*REG_W-1:0] reg_live,
   input logic [NUM_REGS*REG_W-1:0] reg_wdata,
   input logic [NUM_REGS-1:0]       reg_load,
   input logic [BUS_W-1:0]          temp_q
);

   logic             c_mapped;
   logic [BUS_W-1:0] c_live_hi;
   logic [REG_W-1:0] c_wdata;
   logic             c_hi;

   assign c_hi = bus_addr[0];

   always_comb begin
      c_mapped  = 1'b0;
      c_live_hi = '0;
      c_wdata   = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (int'(bus_addr >> 1) == k) begin
            c_mapped  = 1'b1;
            c_live_hi = reg_live[k*REG_W + BUS_W +: BUS_W];
            c_wdata   = reg_wdata[k*REG_W +: REG_W];
         end
      end
   end

   a_r3_load_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_load));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !bus_rd) |-> (reg_load == '0 && bus_rdata == '0));

   a_r2_hi_write_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && c_hi) |-> reg_load == '0);

   a_r2_hi_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && c_mapped && c_hi) |=> temp_q == $past(bus_wdata));

   a_r3_write_value: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && c_mapped && !c_hi) |-> (c_wdata == {temp_q, bus_wdata} && $countones(reg_load) == 1));

   a_r5_capture_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && c_mapped && !c_hi) |=> temp_q == $past(c_live_hi));

   a_r6_hi_read_temp: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && c_mapped && c_hi) |-> bus_rdata == temp_q);

   a_r8_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !c_mapped |-> (reg_load == '0 && bus_rdata == '0));

   a_r8_unmapped_keeps_temp: assert property (@(posedge clk) disable iff (!rst_n)
      !c_mapped |=> temp_q == $past(temp_q));

   a_r9_both_strobes_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_rd) |-> bus_rdata == '0);

endmodule

bind wide_reg_bridge wrb_checker #(
   .NUM_REGS (NUM_REGS),
   .BUS_W    (BUS_W),
   .REG_W    (REG_W),
   .ADDR_W   (ADDR_W)
) u_wrb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .reg_live  (reg_live),
   .reg_wdata (reg_wdata),
   .reg_load  (reg_load),
   .temp_q    (temp_q)
);

// File: tb/tb_wide_reg_bridge.sv
module tb_wide_reg_bridge;

   localparam int NR = 4;
   localparam int BW = 8;
   localparam int RW = 16;
   localparam int AW = 4;
   localparam time HALF = 2ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [BW-1:0]     bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [BW-1:0]     bus_rdata;
   logic [NR*RW-1:0]  reg_live;
   logic [NR*RW-1:0]  reg_wdata;
   logic [NR-1:0]     reg_load;

   logic [RW-1:0]     live_m [NR];
   logic [BW-1:0]     m_temp;
   logic [BW-1:0]     last_rdata;
   int                n_vec = 0;
   int                n_bad = 0;
   bit                done = 1'b0;

   always #HALF clk = ~clk;

   always_comb begin
      for (int k = 0; k < NR; k++) reg_live[k*RW +: RW] = live_m[k];
   end

   wide_reg_bridge #(.NUM_REGS(NR), .BUS_W(BW), .REG_W(RW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .reg_live(reg_live), .reg_wdata(reg_wdata), .reg_load(reg_load));

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] exp_rdata(input logic [AW-1:0] a, input bit wr, input bit rd);
      int idx = int'(a >> 1);
      if (!rd || wr || idx >= NR) return '0;
      return a[0] ? m_temp : live_m[idx][BW-1:0];
   endfunction

   function automatic logic [NR-1:0] exp_load(input logic [AW-1:0] a, input bit wr);
      int idx = int'(a >> 1);
      if (!wr || idx >= NR || a[0]) return '0;
      return NR'(1) << idx;
   endfunction

   // One bus cycle: drive at the falling edge, compare before the rising edge,
   // then advance the bench model past the rising edge.
   task automatic apply(input logic [AW-1:0] a, input logic [BW-1:0] d,
                        input bit wr, input bit rd, input string tag);
      int idx = int'(a >> 1);
      logic [NR-1:0] el;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = rd;
      #1;
      last_rdata = bus_rdata;
      el = exp_load(a, wr);
      check(bus_rdata == exp_rdata(a, wr, rd), {tag, " rdata"}, 32'(bus_rdata), 32'(exp_rdata(a, wr, rd)));
      check(reg_load == el, {tag, " load"}, 32'(reg_load), 32'(el));
      if (el != '0)
         check(reg_wdata[idx*RW +: RW] == {m_temp, d}, {tag, " wdata"},
               32'(reg_wdata[idx*RW +: RW]), 32'({m_temp, d}));
      @(posedge clk);
      #1;
      if (idx < NR) begin
         if (wr && a[0]) m_temp = d;
         else if (wr && !a[0]) live_m[idx] = {m_temp, d};
         else if (rd && !a[0]) m_temp = live_m[idx][RW-1:BW];
      end
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(HALF * 2 * 200000);
      n_bad++;
      $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < NR; k++) live_m[k] = 16'h1111 * (k + 1);
      m_temp = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: holding byte starts at zero
      apply(4'd1, 8'h00, 0, 1, "R1 reset temp");
      check(last_rdata == 8'h00, "R1 literal", 32'(last_rdata), 32'h0);
      apply(4'd0, 8'h00, 0, 0, "R10 idle");
      // R2 / R6 / R7: high write goes only to the shared byte
      apply(4'd3, 8'h5A, 1, 0, "R2 hi write");
      apply(4'd5, 8'h00, 0, 1, "R6 R7 shared hi read");
      check(last_rdata == 8'h5A, "R7 literal", 32'(last_rdata), 32'h5A);
      // R3: low write merges
      apply(4'd2, 8'h34, 1, 0, "R3 low write");
      check(live_m[1] == 16'h5A34, "R3 literal", 32'(live_m[1]), 32'h5A34);
      apply(4'd1, 8'hC3, 1, 0, "R7 hi via reg0");
      apply(4'd6, 8'h11, 1, 0, "R7 low to reg3");
      check(live_m[3] == 16'hC311, "R7 cross literal", 32'(live_m[3]), 32'hC311);
      // R4 / R5 / R6: capture on low read, high read returns captured byte
      live_m[2] = 16'hBEEF;
      apply(4'd4, 8'h00, 0, 1, "R4 low read");
      check(last_rdata == 8'hEF, "R4 literal", 32'(last_rdata), 32'hEF);
      live_m[2] = 16'h1234;
      apply(4'd5, 8'h00, 0, 1, "R5 R6 captured hi");
      check(last_rdata == 8'hBE, "R5 literal", 32'(last_rdata), 32'hBE);
      // R8: unmapped addresses
      apply(4'd9, 8'h77, 1, 0, "R8 unmapped hi write");
      apply(4'd12, 8'h77, 1, 0, "R8 unmapped low write");
      apply(4'd14, 8'h00, 0, 1, "R8 unmapped low read");
      apply(4'd1, 8'h00, 0, 1, "R8 temp kept");
      check(last_rdata == 8'hBE, "R8 literal", 32'(last_rdata), 32'hBE);
      // R9: both strobes act as a write
      live_m[0] = 16'hA5A5;
      apply(4'd0, 8'h66, 1, 1, "R9 both strobes");
      apply(4'd3, 8'h00, 0, 1, "R9 no capture");
      check(last_rdata == 8'hBE, "R9 literal", 32'(last_rdata), 32'hBE);

      // Random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] a = AW'($urandom_range(0, 15));
         logic [BW-1:0] d = BW'($urandom);
         bit wr = ($urandom % 3) == 0;
         bit rd = ($urandom % 2) == 1;
         if (($urandom % 8) == 0) live_m[$urandom % NR] = RW'($urandom);
         apply(a, d, wr, rd, "R2 R3 R4 R5 R6 R8 R9 R10 random");
      end
      finish_run();
   end

endmodule